// File: doc/BRIEF.md
# Multiplexed Detect Pin Demultiplexer

This block takes one shared detector input pin that carries two status signals in turn and splits it into two held status bits: a loop-detect bit and a ground-key bit. It is driven by a one-cycle 64 kHz tick strobe, so one tick period is 15.625 µs. The block runs a frame of 13 tick periods. In the first period of the frame it drives an outgoing multiplex pulse, which the external detector uses to align itself. In the second period it opens the ground-key sampling window, and in the third period it opens the loop-detect sampling window. The remaining periods are idle.

While a window is open, its status bit follows the pin, one clock behind. At all other times the bit keeps its last value, and pin activity outside both windows has no effect. When multiplexing is switched off, the pin carries only loop-detect status. The loop-detect bit then follows the pin on every clock, the ground-key bit holds, and the pulse and both windows stay low. Turning multiplexing back on starts a new frame, and the first tick after that presents the pulse.

Top module: `dmx_detect_demux`

## Requirements
- R1: A synchronous active-high reset clears the frame position, `mux_pulse`, `gk_window`, `ld_window`, `gk_status` and `ld_status`.
- R2: With `mux_en` high, the frame is 13 tick periods long. `mux_pulse` is high for exactly one tick period out of every 13 ticks.
- R3: The pulse and both windows change only on the clock edge that samples `tick` high, one clock after the strobe is applied. Each one stays high for exactly one tick period.
- R4: The frame slots are the pulse in slot 0, the ground-key window in slot 1 and the loop-detect window in slot 2, and slots 3 to 12 are idle. The first tick after reset or enable presents slot 0. At most one of the three outputs is high at any time.
- R5: While `gk_window` is high, `gk_status` takes the value of `det_pin` on each clock edge. Otherwise it holds.
- R6: While `ld_window` is high and `mux_en` is high, `ld_status` takes the value of `det_pin` on each clock edge. Otherwise it holds.
- R7: Changes on `det_pin` while neither window is open leave both status bits unchanged.
- R8: With `mux_en` low, `mux_pulse`, `gk_window` and `ld_window` are low from the next clock onward. `ld_status` takes `det_pin` on every clock edge, and `gk_status` holds, including when it is disabled in the middle of a ground-key window.
- R9: Raising `mux_en` leaves the outputs low until the next tick, which then presents slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | 64 kHz strobe, one clock wide |
| mux_en | input | 1 | Enables time-shared operation of the pin |
| det_pin | input | 1 | Shared detector pin (already synchronous) |
| mux_pulse | output | 1 | Outgoing multiplex pulse, one tick period per frame |
| gk_window | output | 1 | Ground-key sampling window |
| ld_window | output | 1 | Loop-detect sampling window |
| gk_status | output | 1 | Held ground-key status |
| ld_status | output | 1 | Held loop-detect status |

## Verification
The bench walks the design through more than two full frames while the pin toggles in every slot. This catches a counter that wraps at 12 or 14, and slots that are swapped or decoded one tick late.

The bench also changes the pin on the same edge that closes a window. A design that captures with the decoded slot instead of the registered window would miss the last sample or take one extra, and the status bits would then disagree.

Disabling in the middle of a ground-key window checks that the ground-key bit freezes and that the loop-detect bit switches to direct tracking. A design that gates the enable late would overwrite the ground-key bit.

Re-enabling checks that the frame restarts at the pulse rather than resuming from where it stopped.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
   // status channels fed from the shared pin
   typedef enum logic [0:0] {
      CH_LD = 1'b0,
      CH_GK = 1'b1
   } dmx_ch_e;

   localparam int unsigned NUM_CH    = 2;
   localparam int unsigned NUM_SLOTS = 3;  // pulse, ground-key, loop-detect

   function automatic bit slots_valid(int unsigned len, int unsigned a,
                                      int unsigned b, int unsigned c);
      return (a < len) && (b < len) && (c < len) && (a != b) && (b != c) && (a != c);
   endfunction
endpackage

// File: rtl/dmx_frame_timer.sv
module dmx_frame_timer #(
   parameter int unsigned FRAME_LEN  = 13,
   parameter int unsigned PULSE_SLOT = 0,
   parameter int unsigned GK_SLOT    = 1,
   parameter int unsigned LD_SLOT    = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic mux_en,
   output logic pulse_o,
   output logic gk_win_o,
   output logic ld_win_o
);
   import dmx_pkg::*;

   localparam int unsigned CW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
   localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

   generate
      if (FRAME_LEN < 4) begin : g_bad_len
         $error("dmx_frame_timer: FRAME_LEN must be at least 4");
      end
      if (!slots_valid(FRAME_LEN, PULSE_SLOT, GK_SLOT, LD_SLOT)) begin : g_bad_slot
         $error("dmx_frame_timer: slots must be distinct and inside the frame");
      end
   endgenerate

   localparam int unsigned SLOT_POS [NUM_SLOTS] = '{PULSE_SLOT, GK_SLOT, LD_SLOT};

   logic [CW-1:0]        next_slot;   // slot presented by the next tick
   logic [NUM_SLOTS-1:0] hit;
   logic [NUM_SLOTS-1:0] win_q;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_dec
      assign hit[s] = (next_slot == CW'(SLOT_POS[s]));
   end

   always_ff @(posedge clk) begin
      if (rst || !mux_en) begin
         next_slot <= '0;
         win_q     <= '0;
      end else if (tick) begin
         win_q     <= hit;
         next_slot <= (next_slot == LAST) ? '0 : next_slot + 1'b1;
      end
   end

   assign pulse_o  = win_q[0];
   assign gk_win_o = win_q[1];
   assign ld_win_o = win_q[2];

   // R4: never more than one slot output active
   assert_one_slot_R4: assert property (@(posedge clk) disable iff (rst)
      $onehot0({pulse_o, gk_win_o, ld_win_o}));

   // R3: outputs move only on tick edges
   assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (rst)
      (mux_en && !tick) |=> $stable({pulse_o, gk_win_o, ld_win_o}));

   // R4: ground-key window directly follows the pulse
   assert_gk_after_pulse_R4: assert property (@(posedge clk) disable iff (rst)
      (mux_en && tick && pulse_o) |=> gk_win_o);

   // R4: loop-detect window directly follows the ground-key window
   assert_ld_after_gk_R4: assert property (@(posedge clk) disable iff (rst)
      (mux_en && tick && gk_win_o) |=> ld_win_o);

   // R8: disabled means quiet slot outputs
   assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (rst)
      !mux_en |=> !(pulse_o || gk_win_o || ld_win_o));
endmodule

// File: rtl/dmx_track_hold.sv
module dmx_track_hold #(
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic pin,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst)     q <= RESET_VAL;
      else if (en) q <= pin;
   end

   // R7: closed gate keeps the bit
   assert_hold_closed_R7: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(q));

   // R5: open gate copies the pin
   assert_track_open_R5: assert property (@(posedge clk) disable iff (rst)
      en |=> (q == $past(pin)));
endmodule

// File: rtl/dmx_detect_demux.sv
module dmx_detect_demux #(
   parameter int unsigned FRAME_LEN  = 13,
   parameter int unsigned PULSE_SLOT = 0,
   parameter int unsigned GK_SLOT    = 1,
   parameter int unsigned LD_SLOT    = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic mux_en,
   input  logic det_pin,
   output logic mux_pulse,
   output logic gk_window,
   output logic ld_window,
   output logic gk_status,
   output logic ld_status
);
   import dmx_pkg::*;

   logic [NUM_CH-1:0] cap_en;
   logic [NUM_CH-1:0] stat_q;

   dmx_frame_timer #(
      .FRAME_LEN (FRAME_LEN),
      .PULSE_SLOT(PULSE_SLOT),
      .GK_SLOT   (GK_SLOT),
      .LD_SLOT   (LD_SLOT)
   ) u_timer (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .mux_en  (mux_en),
      .pulse_o (mux_pulse),
      .gk_win_o(gk_window),
      .ld_win_o(ld_window)
   );

   // loop-detect tracks freely when the pin is not shared
   assign cap_en[CH_LD] = mux_en ? ld_window : 1'b1;
   assign cap_en[CH_GK] = mux_en & gk_window;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dmx_track_hold #(.RESET_VAL(1'b0)) u_th (
         .clk(clk),
         .rst(rst),
         .en (cap_en[c]),
         .pin(det_pin),
         .q  (stat_q[c])
      );
   end

   assign ld_status = stat_q[CH_LD];
   assign gk_status = stat_q[CH_GK];

   // R8: ground-key bit frozen while disabled
   assert_gk_frozen_off_R8: assert property (@(posedge clk) disable iff (rst)
      !mux_en |=> $stable(gk_status));

   // R8: loop-detect bit follows the pin while disabled
   assert_ld_direct_off_R8: assert property (@(posedge clk) disable iff (rst)
      !mux_en |=> (ld_status == $past(det_pin)));

   // R1: reset leaves everything low
   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> !(mux_pulse || gk_window || ld_window || gk_status || ld_status));
endmodule

// File: tb/sim_dmx_detect_demux.sv
module sim_dmx_detect_demux;
   localparam int FRAME = 13;
   localparam int GAP   = 3;   // clocks between tick strobes after the strobe clock

   logic clk = 1'b0;
   logic rst, tick, mux_en, det_pin;
   logic mux_pulse, gk_window, ld_window, gk_status, ld_status;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // expected-value model
   int   k;          // ticks since enable
   int   prev_slot;  // slot whose window is currently open, -1 if none
   logic e_gk, e_ld;

   always #2 clk = ~clk;

   dmx_detect_demux u0 (
      .clk(clk), .rst(rst), .tick(tick), .mux_en(mux_en), .det_pin(det_pin),
      .mux_pulse(mux_pulse), .gk_window(gk_window), .ld_window(ld_window),
      .gk_status(gk_status), .ld_status(ld_status)
   );

   task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b (pulse,gkw,ldw,gk,ld)", req, act, exp);
      end
   endtask

   function automatic logic [4:0] outs();
      return {mux_pulse, gk_window, ld_window, gk_status, ld_status};
   endfunction

   function automatic logic [2:0] wins(input int slot);
      return {slot == 0, slot == 1, slot == 2};
   endfunction

   // apply one tick with the pin set to pv; checks right after the edge and at end of period
   task automatic tick_once(input logic pv, input string req);
      int slot;
      det_pin = pv;
      tick    = 1'b1;
      if (prev_slot == 1) e_gk = pv;   // closing window samples on the tick edge
      if (prev_slot == 2) e_ld = pv;
      @(negedge clk);
      tick = 1'b0;
      slot = k % FRAME;
      k++;
      chk(req, outs(), {wins(slot), e_gk, e_ld});
      repeat (GAP) @(negedge clk);
      if (slot == 1) e_gk = pv;
      if (slot == 2) e_ld = pv;
      chk(req, outs(), {wins(slot), e_gk, e_ld});
      prev_slot = slot;
   endtask

   task automatic enable_fresh();
      mux_en    = 1'b1;
      @(negedge clk);
      k         = 0;
      prev_slot = -1;
      chk("R9 idle before first tick", outs(), {3'b000, e_gk, e_ld});
   endtask

   task automatic t_reset();
      rst = 1'b1; tick = 1'b0; mux_en = 1'b1; det_pin = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 reset state", outs(), 5'b00000);
      rst = 1'b0;
      e_gk = 1'b0; e_ld = 1'b0; k = 0; prev_slot = -1;
      @(negedge clk);
      chk("R1 held low after reset", outs(), 5'b00000);
   endtask

   task automatic t_frame_walk();
      for (int i = 0; i < 2 * FRAME + 2; i++) begin
         tick_once(logic'(((i * 7 + 3) % 5) < 2), "R2 R3 R4 R5 R6 frame walk");
      end
   endtask

   task automatic t_capture();
      mux_en = 1'b0; det_pin = 1'b0;
      @(negedge clk);
      e_ld = 1'b0;
      enable_fresh();
      tick_once(1'b1, "R7 pin ignored in pulse slot");
      tick_once(1'b1, "R5 ground-key captured");
      tick_once(1'b1, "R6 loop-detect captured");
      // idle slots with pin toggling between clocks
      for (int i = 0; i < FRAME - 3; i++) begin
         det_pin = 1'b0;
         tick = 1'b1;
         if (prev_slot == 2) e_ld = 1'b0;
         @(negedge clk);
         tick = 1'b0; k++; prev_slot = 3 + i;
         for (int j = 0; j < GAP; j++) begin
            det_pin = logic'(j[0]);
            @(negedge clk);
         end
         chk("R7 idle slot ignores pin", outs(), {3'b000, e_gk, e_ld});
      end
      tick_once(1'b0, "R2 pulse again after 13 ticks");
      tick_once(1'b0, "R5 ground-key recaptured low");
      chk("R6 loop-detect kept", {3'b000, ld_status, 1'b0}, {3'b000, e_ld, 1'b0});
   endtask

   task automatic t_disabled();
      mux_en = 1'b0;
      prev_slot = -1;
      for (int i = 0; i < 12; i++) begin
         det_pin = logic'((i % 3) == 0);
         tick    = logic'((i % 4) == 0);
         e_ld    = det_pin;
         @(negedge clk);
         chk("R8 disabled: direct loop-detect, no windows", outs(), {3'b000, e_gk, e_ld});
      end
      tick = 1'b0;
   endtask

   task automatic t_disable_mid_gk();
      det_pin = 1'b0;
      @(negedge clk);
      e_ld = 1'b0;
      enable_fresh();
      tick_once(1'b0, "R4 pulse slot");
      // open ground-key window with pin high
      det_pin = 1'b1; tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
      e_gk = 1'b1;
      chk("R5 gk captured before disable", outs(), {3'b010, e_gk, e_ld});
      mux_en = 1'b0; det_pin = 1'b0;
      @(negedge clk);
      e_ld = 1'b0;
      chk("R8 disable mid-window holds gk", outs(), {3'b000, e_gk, e_ld});
      enable_fresh();
      tick_once(1'b1, "R9 re-enable restarts at pulse");
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_frame_walk();
      t_capture();
      t_disabled();
      t_disable_mid_gk();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule